// File: doc/BRIEF.md
# Parallel Multi-Bit PRBS Generator

This block produces a maximal-length pseudo-random bit stream several bits at a time. It is meant for links whose serial bit rate is above the rate the logic can be clocked at. Every clock it hands an external serializer a word of M bits. The serializer sends bit 0 of the word first. The word holds exactly the bits that a one-bit-per-clock shift-register generator of the same polynomial would have sent over M of its own clocks.

The state register is no larger than the serial generator's. The next-state logic is a jump of M serial steps, folded at elaboration into one XOR network per state bit. The word bits come from a second set of XOR networks, each of which looks ahead a fixed number of serial steps from the present state. The register length, the feedback tap mask, the word width M and the feedback kind (XOR or XNOR) are parameters. A seed can be loaded at any time. A seed that would freeze the generator is replaced by a safe value.

State convention: bit i of the state is stage i+1 of the serial shift register. A serial step moves each stage into the next one and writes the feedback into bit 0. The feedback is the XOR (or XNOR) of the stages picked by the tap mask. The serial output is the top stage, bit N-1.

Top module: `prbs_par_gen`

## Requirements
- R1: While rst_n is low at a rising edge, the state is set to the reset seed, which is all ones by default. Reset wins over load and enable. Right after reset, word bit j equals serial output bit j counted from that seed.
- R2: On each rising edge with en high and load low, the state advances by exactly M serial steps. Word k after a seed therefore carries serial bits k·M to k·M+M-1.
- R3: The word is in send order. Bit 0 is the serial output of the current state, and bit j is the serial output j steps later.
- R4: With en and load both low, the state and the word stay unchanged.
- R5: load high at a rising edge takes the seed input, whatever en is. The next word is then the first M serial bits from that seed.
- R6: A loaded seed equal to the lock-up value is replaced by its bitwise inverse. The lock-up value is all zeros for XOR feedback and all ones for XNOR feedback.
- R7: Out of reset, the state never holds the lock-up value. With the default 4-bit register this means the stream never contains four zero bits in a row.
- R8: With the default polynomial (taps on stages 3 and 4, mask 4'b1100, XOR) and M=2, the word stream repeats every 15 words.
- R9: Default case, seeded with all ones: the first four words are 2'b11, 2'b11, 2'b00 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance the state by M serial steps |
| load | input | 1 | Load the seed input (after the lock-up guard) |
| seed | input | N | Seed value, bit i is stage i+1 |
| word | output | M | Current output word, bit 0 sent first |

## Verification
The bench steps a behavioural serial generator M times for every enabled clock and compares each word against it. It uses three starting points: the reset seed, an arbitrary loaded seed, and a lock-up seed that must be replaced. Matching from more than one seed separates a correct M-step jump from one that only works on a single orbit. The fixed first words from the all-ones seed catch a reversed bit order within the word. A 15-word repeat test catches a wrong polynomial, and runs with enable held low separate hold from advance.

// File: rtl/prbs_pkg.sv
// Package: shared types for the parallel PRBS generator.
// Assumes: nothing beyond IEEE 1800-2017.
package prbs_pkg;

    // Kind of feedback gate closing the serial shift register
    typedef enum logic {
        FB_XOR  = 1'b0,
        FB_XNOR = 1'b1
    } fb_kind_e;

endpackage

// File: rtl/prbs_seed_guard.sv
// Module: prbs_seed_guard
// Swaps a seed that equals the lock-up value for its inverse, which
// always sits on the maximal-length orbit.
// Assumes: N >= 2; FB_KIND picks which value locks up.
module prbs_seed_guard #(
    parameter int                 N       = 4,
    parameter prbs_pkg::fb_kind_e FB_KIND = prbs_pkg::FB_XOR
) (
    input  logic [N-1:0] seed_in,
    output logic [N-1:0] seed_out
);
    localparam logic [N-1:0] LOCK = (FB_KIND == prbs_pkg::FB_XNOR) ? {N{1'b1}} : {N{1'b0}};
    localparam logic [N-1:0] SAFE = ~LOCK;

    // replace the lock-up value, pass any other seed through
    always_comb begin
        seed_out = (seed_in == LOCK) ? SAFE : seed_in;
    end
endmodule

// File: rtl/prbs_jump_net.sv
// Module: prbs_jump_net
// Next-state logic that jumps M serial steps in one go. At elaboration,
// each state bit is followed symbolically through M shifts as a set of
// GF(2) coefficients over the present state plus a constant term. Each
// row then becomes one XOR tree.
// Assumes: bit i = stage i+1, feedback enters bit 0, TAPS marks stages.
module prbs_jump_net #(
    parameter int                 N       = 4,
    parameter int                 M       = 2,
    parameter logic [N-1:0]       TAPS    = 4'b1100,
    parameter prbs_pkg::fb_kind_e FB_KIND = prbs_pkg::FB_XOR
) (
    input  logic [N-1:0] state,
    output logic [N-1:0] next
);
    localparam int W = N + 1;   // coefficients plus constant term

    // symbolic state after M serial steps
    function automatic logic [N-1:0][W-1:0] jump_rows();
        logic [N-1:0][W-1:0] cur;
        logic [N-1:0][W-1:0] nxt;
        logic [W-1:0]        fb;
        for (int i = 0; i < N; i++) begin
            cur[i]    = '0;
            cur[i][i] = 1'b1;
        end
        for (int s = 0; s < M; s++) begin
            fb = '0;
            fb[N] = (FB_KIND == prbs_pkg::FB_XNOR);
            for (int j = 0; j < N; j++) begin
                if (TAPS[j]) fb = fb ^ cur[j];
            end
            nxt[0] = fb;
            for (int i = 1; i < N; i++) nxt[i] = cur[i-1];
            cur = nxt;
        end
        return cur;
    endfunction

    localparam logic [N-1:0][W-1:0] ROWS = jump_rows();

    for (genvar g = 0; g < N; g++) begin : g_bit
        // one XOR tree per state bit
        assign next[g] = (^(state & ROWS[g][N-1:0])) ^ ROWS[g][N];
    end
endmodule

// File: rtl/prbs_word_taps.sv
// Module: prbs_word_taps
// Output word logic. Bit k is the serial output (top stage) k serial
// steps after the present state, written as an XOR of state bits plus
// a constant. The rows are worked out at elaboration.
// Assumes: same state convention as prbs_jump_net; bit 0 is sent first.
module prbs_word_taps #(
    parameter int                 N       = 4,
    parameter int                 M       = 2,
    parameter logic [N-1:0]       TAPS    = 4'b1100,
    parameter prbs_pkg::fb_kind_e FB_KIND = prbs_pkg::FB_XOR
) (
    input  logic [N-1:0] state,
    output logic [M-1:0] word
);
    localparam int W = N + 1;

    // serial output rows for look-ahead 0..M-1
    function automatic logic [M-1:0][W-1:0] out_rows();
        logic [N-1:0][W-1:0] cur;
        logic [N-1:0][W-1:0] nxt;
        logic [M-1:0][W-1:0] rows;
        logic [W-1:0]        fb;
        for (int i = 0; i < N; i++) begin
            cur[i]    = '0;
            cur[i][i] = 1'b1;
        end
        for (int k = 0; k < M; k++) begin
            rows[k] = cur[N-1];
            fb = '0;
            fb[N] = (FB_KIND == prbs_pkg::FB_XNOR);
            for (int j = 0; j < N; j++) begin
                if (TAPS[j]) fb = fb ^ cur[j];
            end
            nxt[0] = fb;
            for (int i = 1; i < N; i++) nxt[i] = cur[i-1];
            cur = nxt;
        end
        return rows;
    endfunction

    localparam logic [M-1:0][W-1:0] ROWS = out_rows();

    for (genvar k = 0; k < M; k++) begin : g_out
        // one XOR tree per output bit
        assign word[k] = (^(state & ROWS[k][N-1:0])) ^ ROWS[k][N];
    end
endmodule

// File: rtl/prbs_par_gen.sv
// Module: prbs_par_gen (top)
// Parallel PRBS generator: an N-bit state register that moves M serial
// steps per clock. It emits M bits per clock in send order (bit 0
// first). Priority is reset, then load, then enable.
// Assumes: TAPS gives a maximal-length polynomial; RST_SEED is any value
// (a lock-up reset seed is guarded the same way as a loaded one).
module prbs_par_gen #(
    parameter int                 N        = 4,
    parameter int                 M        = 2,
    parameter logic [N-1:0]       TAPS     = 4'b1100,
    parameter prbs_pkg::fb_kind_e FB_KIND  = prbs_pkg::FB_XOR,
    parameter logic [N-1:0]       RST_SEED = {N{1'b1}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic [N-1:0] seed,
    output logic [M-1:0] word
);
    localparam logic [N-1:0] LOCK      = (FB_KIND == prbs_pkg::FB_XNOR) ? {N{1'b1}} : {N{1'b0}};
    localparam logic [N-1:0] RST_STATE = (RST_SEED == LOCK) ? ~LOCK : RST_SEED;

    logic [N-1:0] state_q;
    logic [N-1:0] jump_d;
    logic [N-1:0] seed_ok;

    prbs_seed_guard #(.N(N), .FB_KIND(FB_KIND)) u_guard (
        .seed_in  (seed),
        .seed_out (seed_ok)
    );

    prbs_jump_net #(.N(N), .M(M), .TAPS(TAPS), .FB_KIND(FB_KIND)) u_jump (
        .state (state_q),
        .next  (jump_d)
    );

    prbs_word_taps #(.N(N), .M(M), .TAPS(TAPS), .FB_KIND(FB_KIND)) u_taps (
        .state (state_q),
        .word  (word)
    );

    // state register: reset, then seed load, then M-step advance
    always_ff @(posedge clk) begin
        if (!rst_n)    state_q <= RST_STATE;
        else if (load) state_q <= seed_ok;
        else if (en)   state_q <= jump_d;
    end
endmodule

// File: rtl/prbs_par_gen_chk.sv
// Module: prbs_par_gen_chk
// Assertion checker bound to prbs_par_gen; watches the ports and the
// state register.
// Assumes: bound with the same parameters as the generator.
module prbs_par_gen_chk #(
    parameter int                 N        = 4,
    parameter int                 M        = 2,
    parameter prbs_pkg::fb_kind_e FB_KIND  = prbs_pkg::FB_XOR,
    parameter logic [N-1:0]       RST_SEED = {N{1'b1}}
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         load,
    input logic [N-1:0] seed,
    input logic [N-1:0] state
);
    localparam logic [N-1:0] LOCK  = (FB_KIND == prbs_pkg::FB_XNOR) ? {N{1'b1}} : {N{1'b0}};
    localparam logic [N-1:0] RST_V = (RST_SEED == LOCK) ? ~LOCK : RST_SEED;

    // R1: reset loads the guarded reset seed
    a_r1_reset_seed: assert property (@(posedge clk)
        !rst_n |=> state == RST_V);

    // R4: hold when idle
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(state));

    // R5 / R6: load takes the seed, lock-up seed is inverted
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state == (($past(seed) == LOCK) ? ~LOCK : $past(seed)));

    // R7: lock-up value never held
    a_r7_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        state != LOCK);

    // R2: the lower stages shift up by M positions on each advance
    if (M < N) begin : g_shift
        a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !load) |=> state[N-1:M] == $past(state[N-1-M:0]));
    end
endmodule

bind prbs_par_gen prbs_par_gen_chk #(
    .N(N), .M(M), .FB_KIND(FB_KIND), .RST_SEED(RST_SEED)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .load  (load),
    .seed  (seed),
    .state (state_q)
);

// File: tb/prbs_par_gen_tb.sv
// Bench for prbs_par_gen: a behavioural serial generator is stepped M
// times per enabled clock and compared with the word after every clock.
module prbs_par_gen_tb;
    localparam int           CLK_P = 10;
    localparam int           N     = 4;
    localparam int           M     = 2;
    localparam logic [N-1:0] TAPS  = 4'b1100;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic         en    = 1'b0;
    logic         load  = 1'b0;
    logic [N-1:0] seed  = '0;
    logic [M-1:0] word;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [N-1:0] mdl;
    logic [M-1:0] saved [15];
    logic [M-1:0] prev;

    prbs_par_gen #(.N(N), .M(M), .TAPS(TAPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed), .word(word)
    );

    always #(CLK_P/2) clk = ~clk;

    // one serial shift with XOR feedback
    function automatic logic [N-1:0] serial_step(input logic [N-1:0] s);
        return {s[N-2:0], ^(s & TAPS)};
    endfunction

    // serial bits 0..M-1 from a given state, first bit in position 0
    function automatic logic [M-1:0] exp_word(input logic [N-1:0] s);
        logic [M-1:0] w;
        logic [N-1:0] t;
        t = s;
        for (int j = 0; j < M; j++) begin
            w[j] = t[N-1];
            t = serial_step(t);
        end
        return w;
    endfunction

    task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive inputs away from the edge, clock once, update the model
    task automatic tick(input logic e, input logic l, input logic [N-1:0] sd);
        en = e; load = l; seed = sd;
        @(posedge clk);
        #1;
        if (!rst_n)      mdl = '1;
        else if (l)      mdl = (sd == '0) ? '1 : sd;
        else if (e) begin
            for (int s = 0; s < M; s++) mdl = serial_step(mdl);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mdl = '1;
        #2;
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 4'b0110);
        check("R1 reset seed", word, exp_word(4'b1111));
        rst_n = 1'b1;

        // R9: fixed words from all ones
        check("R9 word0", word, 2'b11);
        tick(1'b1, 1'b0, '0); check("R9 word1", word, 2'b11);
        tick(1'b1, 1'b0, '0); check("R9 word2", word, 2'b00);
        tick(1'b1, 1'b0, '0); check("R9 word3 R3 order", word, 2'b10);

        // R2 / R3: run against the serial model
        for (int i = 0; i < 30; i++) begin
            tick(1'b1, 1'b0, '0);
            check("R2 advance", word, exp_word(mdl));
        end

        // R8: period of 15 words
        for (int i = 0; i < 15; i++) begin
            saved[i] = word;
            tick(1'b1, 1'b0, '0);
        end
        for (int i = 0; i < 15; i++) begin
            check("R8 period", word, saved[i]);
            tick(1'b1, 1'b0, '0);
        end

        // R4: hold
        prev = word;
        for (int i = 0; i < 5; i++) begin
            tick(1'b0, 1'b0, 4'b0101);
            check("R4 hold", word, prev);
        end

        // R5: load beats enable
        tick(1'b1, 1'b1, 4'b1010);
        check("R5 load seed", word, exp_word(4'b1010));
        for (int i = 0; i < 6; i++) begin
            tick(1'b1, 1'b0, '0);
            check("R2 after load", word, exp_word(mdl));
        end

        // R6: lock-up seed replaced
        tick(1'b0, 1'b1, 4'b0000);
        check("R6 lockup seed", word, exp_word(4'b1111));

        // R7: no four zero bits in a row
        prev = word;
        for (int i = 0; i < 20; i++) begin
            tick(1'b1, 1'b0, '0);
            check("R2 after guard", word, exp_word(mdl));
            checks++;
            if ({prev, word} === 4'b0000) begin
                errors++;
                $display("FAIL R7 lockup actual=%b expected=nonzero", {prev, word});
            end
            prev = word;
        end

        // R1: reset mid-run beats load
        rst_n = 1'b0;
        tick(1'b1, 1'b1, 4'b0101);
        check("R1 reset priority", word, exp_word(4'b1111));
        rst_n = 1'b1;
        tick(1'b1, 1'b0, '0);
        check("R2 after reset", word, exp_word(mdl));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule